// File: doc/BRIEF.md
# Display Panel Reset Pulse Sequencer

This block drives the hardware reset line of an attached display panel. Software writes a control word that holds a pulse width, a pulse count and a start bit. The block then emits a burst of active-low reset pulses on the panel line. Each pulse and each gap between pulses lasts a whole number of timebase ticks. The timebase is a prescaled copy of the core clock, and its period is a power of two picked by a ratio input. A long reset can be built either from a slow timebase or from several pulses in a row.

When the last pulse ends, a raw done flag is set. It stays set until software writes a 1 to the clear register. An interrupt output shows the done flag unless the mask bit blocks it. The mask bit is set (masked) after reset.

Register map, selected by `wr_addr` when `wr_en` is high. Address 0 is the control word: bits [5:0] hold the width W, bits [8:6] hold the count C, and bit 15 is start. Address 1 is the clear register, where bit 0 written as 1 clears done. Address 2 is the mask register: bit 0 at 1 blocks the interrupt.

Top module: `disp_rst_seq`

## Requirements
- R1: After reset, `panel_rst_n` is 1, `busy` is 0, `done_raw` is 0, and `irq` is 0 because the mask bit resets to 1.
- R2: A control write with bit 15 set, made while idle, drives `panel_rst_n` low from the next cycle. The first low phase lasts exactly (W+1)·2^ratio clock cycles, where W is bits [5:0].
- R3: The sequence emits exactly C+1 low pulses, where C is bits [8:6]. Every pulse and every gap between two pulses lasts (W+1)·2^ratio cycles.
- R4: `busy` is 1 from the cycle after the start write for (2(C+1)−1)·(W+1)·2^ratio cycles. `busy` falls on the same edge where the line returns high for the last time.
- R5: `done_raw` rises on the edge where `busy` falls. It stays at 1 until a write to address 1 with bit 0 at 1. A write there with bit 0 at 0 leaves it set.
- R6: `irq` is 1 exactly when `done_raw` is 1 and mask bit 0 (address 2) is 0.
- R7: A control write with the start bit set while `busy` is 1 is ignored. The running burst keeps its width, count and total length.
- R8: If a clear write falls on the same edge that completes a sequence, `done_raw` ends up at 1.
- R9: The ratio is captured at start. A change on `ratio` during a sequence does not alter its timing.
- R10: A control write with bit 15 at 0 starts nothing: `busy` stays 0 and the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 clear, 2 mask |
| wr_data | input | 16 | Register write data |
| ratio | input | 4 | Timebase exponent; one tick is 2^ratio cycles |
| panel_rst_n | output | 1 | Active-low panel reset line |
| busy | output | 1 | Sequence in progress |
| done_raw | output | 1 | Raw completion flag, cleared by writing 1 |
| irq | output | 1 | Masked completion interrupt |

## Verification
Sequence completion and a software clear of the done flag can land on the same clock edge. The bench provokes this by timing a clear write to the exact cycle at which it expects the last pulse to end. That cycle is worked out from the width, count and ratio. The result is judged by checking that `done_raw` reads 1 afterwards. The same timing method places a second start write and a ratio change in the middle of a burst, and checks that the measured pulse lengths, gap lengths and busy span stay unchanged.

// File: rtl/disp_rst_pkg.sv
package disp_rst_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned WID_W     = 6;
  localparam int unsigned CNT_W     = 3;
  localparam int unsigned RATIO_W   = 4;
  localparam int unsigned START_BIT = 15;
  localparam int unsigned PRE_W     = (1 << RATIO_W) - 1;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  // last prescaler count before a tick: 2^ratio - 1
  function automatic logic [PRE_W-1:0] tick_limit(input logic [RATIO_W-1:0] r);
    logic [PRE_W:0] one_hot;
    one_hot = '0;
    one_hot[r] = 1'b1;
    return PRE_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/disp_rst_timebase.sv
module disp_rst_timebase
  import disp_rst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seq_start,
  input  logic               running,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [RATIO_W-1:0] ratio_q;
  logic [PRE_W-1:0]   cnt_q;
  logic [PRE_W-1:0]   lim;

  assign lim  = tick_limit(ratio_q);
  assign tick = running && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      cnt_q   <= '0;
    end else if (seq_start) begin
      ratio_q <= ratio;
      cnt_q   <= '0;
    end else if (running) begin
      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
  end

  // R9: captured ratio does not move while a sequence runs
  p_ratio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !seq_start) |=> $stable(ratio_q));
endmodule

// File: rtl/disp_rst_engine.sv
module disp_rst_engine
  import disp_rst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [WID_W-1:0] width_in,
  input  logic [CNT_W-1:0] count_in,
  input  logic             tick,
  output logic             seq_start,
  output logic             seq_finish,
  output logic             running,
  output logic             line_n
);
  seq_state_e       state_q;
  logic [WID_W-1:0] width_q;
  logic [WID_W-1:0] phase_q;
  logic [CNT_W-1:0] left_q;
  logic             phase_end;

  assign running    = (state_q != ST_IDLE);
  assign seq_start  = start_req && !running;
  assign phase_end  = tick && (phase_q == width_q);
  assign seq_finish = (state_q == ST_LOW) && phase_end && (left_q == '0);
  assign line_n     = (state_q != ST_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      width_q <= '0;
      phase_q <= '0;
      left_q  <= '0;
    end else if (seq_start) begin
      state_q <= ST_LOW;
      width_q <= width_in;
      left_q  <= count_in;
      phase_q <= '0;
    end else if (tick) begin
      if (phase_end) begin
        phase_q <= '0;
        case (state_q)
          ST_LOW:  state_q <= (left_q == '0) ? ST_IDLE : ST_GAP;
          ST_GAP: begin
            state_q <= ST_LOW;
            left_q  <= left_q - 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  // R7: start during a burst leaves the latched width alone
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_req && !seq_finish) |=> (running && $stable(width_q)));
  // R3: a gap is always followed by another pulse
  p_gap_has_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> (left_q != '0));
endmodule

// File: rtl/disp_rst_status.sv
module disp_rst_status
  import disp_rst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_finish,
  input  logic              clr_req,
  input  logic              mask_wr,
  input  logic              mask_val,
  output logic              done_q,
  output logic              irq
);
  logic mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      if (seq_finish)   done_q <= 1'b1;
      else if (clr_req) done_q <= 1'b0;
      if (mask_wr)      mask_q <= mask_val;
    end
  end

  assign irq = done_q & ~mask_q;

  // R8: completion wins over a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> done_q);
  // R5: flag is held unless cleared
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_req) |=> done_q);
  // R6: interrupt only with the flag set
  p_irq_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q);
endmodule

// File: rtl/disp_rst_seq.sv
module disp_rst_seq
  import disp_rst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [RATIO_W-1:0] ratio,
  output logic               panel_rst_n,
  output logic               busy,
  output logic               done_raw,
  output logic               irq
);
  logic start_req, clr_req, mask_wr;
  logic seq_start, seq_finish, running, tick, line_n;

  assign start_req = wr_en && (wr_addr == A_CTRL) && wr_data[START_BIT];
  assign clr_req   = wr_en && (wr_addr == A_CLR)  && wr_data[0];
  assign mask_wr   = wr_en && (wr_addr == A_MASK);

  disp_rst_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start),
    .running(running), .ratio(ratio), .tick(tick)
  );

  disp_rst_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .width_in(wr_data[WID_W-1:0]),
    .count_in(wr_data[WID_W+CNT_W-1:WID_W]),
    .tick(tick), .seq_start(seq_start), .seq_finish(seq_finish),
    .running(running), .line_n(line_n)
  );

  disp_rst_status u_st (
    .clk(clk), .rst_n(rst_n), .seq_finish(seq_finish),
    .clr_req(clr_req), .mask_wr(mask_wr), .mask_val(wr_data[0]),
    .done_q(done_raw), .irq(irq)
  );

  assign panel_rst_n = line_n;
  assign busy        = running;

  // R1/R4: line is low only inside a sequence
  p_low_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> busy);
  // R5: done rises only as busy ends
  p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_raw) |-> ($past(busy) && !busy && panel_rst_n));
  // R2: a start from idle pulls the line low next cycle
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy) |=> !panel_rst_n);
endmodule

// File: tb/disp_rst_seq_tb.sv
module disp_rst_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  ratio = '0;
  logic        panel_rst_n, busy, done_raw, irq;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  disp_rst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ratio(ratio), .panel_rst_n(panel_rst_n),
    .busy(busy), .done_raw(done_raw), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive a one-cycle write starting at a negedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(input int w, input int c, input bit st);
    return {st, 6'd0, 3'(c), 6'(w)};
  endfunction

  // kind: 0 none, 1 start, 2 clear, 3 ratio change
  task automatic run_seq(input int r, input int w, input int c,
                         input int at, input int kind, input int val);
    int p, len, npl, tot, idx, pulses, lowrun, gaprun, busycnt, badlow, badgap;
    bit first_low, prev_low;
    p = 1 << r; len = (w + 1) * p; npl = c + 1; tot = (2 * npl - 1) * len;
    pulses = 0; lowrun = 0; gaprun = 0; busycnt = 0; badlow = 0; badgap = 0;
    prev_low = 1'b0;
    @(negedge clk);
    ratio = 4'(r);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctrl(w, c, 1'b1);
    idx = 0;
    first_low = 1'b0;
    while (idx < 5000) begin
      @(negedge clk);
      idx++;
      wr_en = 1'b0;
      if (idx == 1) first_low = !panel_rst_n;
      if (!busy) break;
      busycnt++;
      if (!panel_rst_n) begin
        if (!prev_low && gaprun != 0 && gaprun != len) badgap++;
        gaprun = 0; lowrun++; prev_low = 1'b1;
      end else begin
        if (prev_low) begin
          pulses++;
          if (lowrun != len) badlow++;
        end
        lowrun = 0; gaprun++; prev_low = 1'b0;
      end
      if (idx == at) begin
        if (kind == 1) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctrl(0, 0, 1'b1); end
        if (kind == 2) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd1; end
        if (kind == 3) ratio = 4'(val);
      end
    end
    if (prev_low) begin
      pulses++;
      if (lowrun != len) badlow++;
    end
    chk(first_low, "R2 line low first cycle", first_low, 1);
    chk(badlow == 0, "R2 R3 pulse length", badlow, 0);
    chk(badgap == 0, "R3 gap length", badgap, 0);
    chk(pulses == npl, "R3 pulse count", pulses, npl);
    chk(busycnt == tot, "R4 busy span", busycnt, tot);
    chk(panel_rst_n == 1'b1, "R4 line high at end", panel_rst_n, 1);
    chk(done_raw == 1'b1, "R5 R8 done at end", done_raw, 1);
    ratio = 4'(r);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(panel_rst_n == 1'b1, "R1 line", panel_rst_n, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done_raw == 1'b0, "R1 done", done_raw, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 no start bit
    wr(2'd0, ctrl(3, 2, 1'b0));
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(panel_rst_n == 1'b1, "R10 line", panel_rst_n, 1);

    // sweep
    for (int r = 0; r < 3; r++) begin
      for (int wi = 0; wi < 4; wi++) begin
        for (int c = 0; c < 4; c++) begin
          int w;
          w = (wi == 3) ? 5 : wi;
          run_seq(r, w, c, 0, 0, 0);
          wr(2'd1, 16'd1);
          chk(done_raw == 1'b0, "R5 cleared", done_raw, 0);
        end
      end
    end

    // R5 write 0 does not clear; R6 mask behaviour
    run_seq(0, 1, 0, 0, 0, 0);
    wr(2'd1, 16'd0);
    chk(done_raw == 1'b1, "R5 write zero keeps", done_raw, 1);
    chk(irq == 1'b0, "R6 masked", irq, 0);
    wr(2'd2, 16'd0);
    chk(irq == 1'b1, "R6 unmasked", irq, 1);
    wr(2'd2, 16'd1);
    chk(irq == 1'b0, "R6 remasked", irq, 0);
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd1);
    chk(irq == 1'b0, "R6 cleared", irq, 0);
    chk(done_raw == 1'b0, "R5 clear", done_raw, 0);

    // R7 start during busy ignored
    run_seq(0, 3, 1, 3, 1, 0);
    wr(2'd1, 16'd1);
    run_seq(1, 2, 2, 10, 1, 0);
    wr(2'd1, 16'd1);

    // R8 clear on completion edge: busy spans (2*2-1)*(2+1)*2 = 18
    run_seq(1, 2, 1, 18, 2, 0);
    @(negedge clk);
    chk(done_raw == 1'b1, "R8 set wins", done_raw, 1);
    wr(2'd1, 16'd1);
    run_seq(0, 0, 0, 1, 2, 0);
    chk(done_raw == 1'b1, "R8 set wins single", done_raw, 1);
    wr(2'd1, 16'd1);

    // R9 ratio change mid-sequence
    run_seq(2, 1, 2, 5, 3, 0);
    wr(2'd1, 16'd1);
    run_seq(0, 4, 1, 2, 3, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule